// File: doc/BRIEF.md
# Vector element issue sequencer

This block sits between scalar instruction decode and the execution units. It takes one decoded instruction at a time. If any operand is flagged as a vector and vectorisation is enabled, it expands the instruction into a sequence of element operations and holds the program counter until the sequence ends. Each element operation reaches the execution unit through a valid/ready issue port. The block keeps the element and sub-element offsets between instructions. A trap can therefore return to the faulting element.

Per-element outcome flags come back from the execution unit in the same cycle as the issue handshake. `res_exc` reports a fault. `res_zero` reports a zero result, and the execution unit raises it for both signs of a floating-point zero.

The sequencer applies three rules to each element:
- **Predication:** one predicate bit covers a whole sub-vector group.
- **Zeroing:** in zeroing mode, a masked-out element is issued as a zero write.
- **Fail-on-first:** a zero result ends the loop early, and the block reports the shortened vector length.

Back-pressure works as follows. `ins_ready` is high only while the block is idle. An instruction is accepted on the clock edge where `ins_valid` and `ins_ready` are both high. An issue request stays valid, with unchanged register numbers, until `iss_ready` is seen high at a clock edge. While it waits, the offsets do not move. The stored offsets must be below the vector length when a vector instruction is accepted.

Top module: `vec_issue_seq`

## Requirements
- R1: `ins_ready` is high only while idle. While an instruction is being expanded, no new instruction is accepted. `done`, the signal that lets the program counter advance, pulses only in the cycle that ends the sequence.
- R2: A vector operand's register number is its base plus the linear index e*SUBVL+s, taken modulo 2^REG_W. A scalar operand keeps its base register.
- R3: Elements are issued strictly in order, one per handshake. The sub-element index s moves fastest. SUBVL is encoded on `subvl` as 0,1,2,3 for 1,2,3,4.
- R4: Bit e of `ins_pred` governs every sub-element of outer element e. An active element is issued with `iss_zero` low.
- R5: In non-zeroing mode, a group whose predicate bit is clear is skipped in a single cycle with no issue, and the offsets move on to the next group.
- R6: In zeroing mode, a masked-out sub-element is issued with `iss_zero` high. Its result flags are ignored.
- R7: A vector instruction starts at the stored offsets, and `elem_offs` and `sub_offs` show them.
- R8: A fault on an active element pulses `trap`, gives no `done`, returns the block to idle and leaves the offsets unchanged.
- R9: After the last sub-element of element VL-1 is issued or skipped, `done` pulses in that cycle and both offsets return to zero.
- R10: In fail-on-first mode, a zero result on active element e pulses `done` and `vl_wr_en` with `vl_wr_val` = e, and resets the offsets.
- R11: In fail-on-first zeroing mode, a masked-out element ends the loop at element e without an issue, with `vl_wr_val` = e. In non-zeroing mode, masked-out elements never end the loop.
- R12: While `iss_valid` is high and `iss_ready` is low, the request, its register numbers and the offsets hold, and neither `done` nor `trap` is raised.
- R13: An instruction with no vector-flagged operand, or with `vl_len` = 0 (vector length register is x0), issues exactly one operation on its base registers. On that handshake it gives `done`, or `trap` on a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Decoded instruction available |
| ins_ready | output | 1 | Sequencer idle and accepting |
| ins_rd | input | REG_W | Destination base register |
| ins_rs1 | input | REG_W | Source 1 base register |
| ins_rs2 | input | REG_W | Source 2 base register |
| ins_vd | input | 1 | Destination is a vector |
| ins_vs1 | input | 1 | Source 1 is a vector |
| ins_vs2 | input | 1 | Source 2 is a vector |
| ins_pred | input | MAXVL | Predicate mask, one bit per outer element |
| ins_zeroing | input | 1 | Zeroing predication mode |
| ins_ffirst | input | 1 | Fail-on-first mode |
| vl_len | input | EW | Vector length, 0 disables vectorisation |
| subvl | input | 2 | Sub-vector length minus one |
| iss_valid | output | 1 | Element operation request |
| iss_ready | input | 1 | Execution unit takes the request |
| iss_rd | output | REG_W | Element destination register |
| iss_rs1 | output | REG_W | Element source 1 register |
| iss_rs2 | output | REG_W | Element source 2 register |
| iss_zero | output | 1 | Write zero to the destination instead |
| res_exc | input | 1 | Issued element faulted (with handshake) |
| res_zero | input | 1 | Issued element result is zero (with handshake) |
| elem_offs | output | OW | Stored outer element offset |
| sub_offs | output | 2 | Stored sub-element offset |
| done | output | 1 | Sequence finished, program counter may advance |
| trap | output | 1 | Sequence stopped on a fault |
| vl_wr_en | output | 1 | Fail-on-first shortened the vector length |
| vl_wr_val | output | EW | New vector length |

## Verification
All issue fields, and `done`, `trap` and `vl_wr_en`, come from a decision path with no registers in the cycle of the handshake or skip. The bench therefore sets `iss_ready` and the result flags at the falling edge, allows them to settle, and compares against its own model before the next rising edge. Acceptance and offset updates take effect at the next rising edge. The offsets are checked at the falling edge that follows, when the next instruction begins. Stalls are inserted on a fixed cycle pattern, and the check for each stalled cycle expects the same request again one cycle later.

// File: rtl/vis_pkg.sv
package vis_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCL  = 2'd1,
    ST_VEC  = 2'd2
  } vis_state_e;

  localparam int unsigned N_OPS = 3;
endpackage

// File: rtl/vis_offset_ctr.sv
module vis_offset_ctr #(
  parameter int unsigned OW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          skip,
  input  logic          adv,
  input  logic [1:0]    smax,
  output logic [OW-1:0] elem,
  output logic [1:0]    sub,
  output logic          grp_end
);
  assign grp_end = (sub == smax);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      elem <= '0;
      sub  <= '0;
    end else if (skip) begin
      elem <= elem + OW'(1);
      sub  <= '0;
    end else if (adv) begin
      if (grp_end) begin
        elem <= elem + OW'(1);
        sub  <= '0;
      end else begin
        sub <= sub + 2'd1;
      end
    end
  end
endmodule

// File: rtl/vis_regmap.sv
module vis_regmap #(
  parameter int unsigned REG_W = 7,
  parameter int unsigned IW    = 5,
  parameter int unsigned NOPS  = 3
) (
  input  logic [NOPS-1:0][REG_W-1:0] base,
  input  logic [NOPS-1:0]            vec,
  input  logic [IW-1:0]              idx,
  output logic [NOPS-1:0][REG_W-1:0] regs
);
  localparam int unsigned SW = REG_W + IW;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    logic [SW-1:0] sum;
    assign sum     = SW'(base[g]) + (vec[g] ? SW'(idx) : '0);
    assign regs[g] = sum[REG_W-1:0];
  end
endmodule

// File: rtl/vis_elem_ctl.sv
module vis_elem_ctl (
  input  logic run_vec,
  input  logic run_scl,
  input  logic pbit,
  input  logic zer,
  input  logic ff,
  input  logic iss_ready,
  input  logic res_exc,
  input  logic res_zero,
  input  logic grp_end,
  input  logic last_elem,
  output logic iss_valid,
  output logic iss_zero,
  output logic adv,
  output logic skip,
  output logic clr,
  output logic done,
  output logic trap,
  output logic vl_wr_en,
  output logic finish
);
  always_comb begin
    iss_valid = 1'b0;
    iss_zero  = 1'b0;
    adv       = 1'b0;
    skip      = 1'b0;
    clr       = 1'b0;
    done      = 1'b0;
    trap      = 1'b0;
    vl_wr_en  = 1'b0;
    finish    = 1'b0;
    if (run_scl) begin
      iss_valid = 1'b1;
      if (iss_ready) begin
        finish = 1'b1;
        trap   = res_exc;
        done   = !res_exc;
      end
    end else if (run_vec) begin
      if (!pbit && !zer) begin
        skip = 1'b1;
        if (last_elem) begin
          done   = 1'b1;
          clr    = 1'b1;
          finish = 1'b1;
        end
      end else if (!pbit && ff) begin
        done     = 1'b1;
        vl_wr_en = 1'b1;
        clr      = 1'b1;
        finish   = 1'b1;
      end else begin
        iss_valid = 1'b1;
        iss_zero  = !pbit;
        if (iss_ready) begin
          if (pbit && res_exc) begin
            trap   = 1'b1;
            finish = 1'b1;
          end else if (pbit && ff && res_zero) begin
            done     = 1'b1;
            vl_wr_en = 1'b1;
            clr      = 1'b1;
            finish   = 1'b1;
          end else begin
            adv = 1'b1;
            if (grp_end && last_elem) begin
              done   = 1'b1;
              clr    = 1'b1;
              finish = 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/vec_issue_seq.sv
module vec_issue_seq #(
  parameter int unsigned REG_W = 7,
  parameter int unsigned MAXVL = 8,
  parameter int unsigned EW    = $clog2(MAXVL + 1),
  parameter int unsigned OW    = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [REG_W-1:0] ins_rd,
  input  logic [REG_W-1:0] ins_rs1,
  input  logic [REG_W-1:0] ins_rs2,
  input  logic             ins_vd,
  input  logic             ins_vs1,
  input  logic             ins_vs2,
  input  logic [MAXVL-1:0] ins_pred,
  input  logic             ins_zeroing,
  input  logic             ins_ffirst,
  input  logic [EW-1:0]    vl_len,
  input  logic [1:0]       subvl,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [REG_W-1:0] iss_rd,
  output logic [REG_W-1:0] iss_rs1,
  output logic [REG_W-1:0] iss_rs2,
  output logic             iss_zero,
  input  logic             res_exc,
  input  logic             res_zero,
  output logic [OW-1:0]    elem_offs,
  output logic [1:0]       sub_offs,
  output logic             done,
  output logic             trap,
  output logic             vl_wr_en,
  output logic [EW-1:0]    vl_wr_val
);
  import vis_pkg::*;

  localparam int unsigned IW = OW + 2;

  vis_state_e st;
  logic [N_OPS-1:0][REG_W-1:0] q_base;
  logic [N_OPS-1:0]            q_vec;
  logic [MAXVL-1:0]            q_pred;
  logic                        q_zer, q_ff;
  logic [EW-1:0]               q_vl;
  logic [1:0]                  q_smax;

  logic accept, in_scalar, finish;
  logic adv, skip, clr, grp_end, last_elem, pbit;
  logic [IW-1:0] idx;
  logic [N_OPS-1:0][REG_W-1:0] regs;
  logic [N_OPS-1:0] vec_eff;

  assign ins_ready = (st == ST_IDLE);
  assign accept    = ins_valid && ins_ready;
  assign in_scalar = !(ins_vd || ins_vs1 || ins_vs2) || (vl_len == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      q_base <= '0;
      q_vec  <= '0;
      q_pred <= '0;
      q_zer  <= 1'b0;
      q_ff   <= 1'b0;
      q_vl   <= '0;
      q_smax <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          st     <= in_scalar ? ST_SCL : ST_VEC;
          q_base <= {ins_rs2, ins_rs1, ins_rd};
          q_vec  <= {ins_vs2, ins_vs1, ins_vd};
          q_pred <= ins_pred;
          q_zer  <= ins_zeroing;
          q_ff   <= ins_ffirst;
          q_vl   <= vl_len;
          q_smax <= subvl;
        end
        default: if (finish) st <= ST_IDLE;
      endcase
    end
  end

  vis_offset_ctr #(.OW(OW)) u_offs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .skip    (skip),
    .adv     (adv),
    .smax    (q_smax),
    .elem    (elem_offs),
    .sub     (sub_offs),
    .grp_end (grp_end)
  );

  assign last_elem = (EW'(elem_offs) == (q_vl - EW'(1)));
  assign pbit      = q_pred[elem_offs];
  assign idx       = IW'(elem_offs) * (IW'(q_smax) + IW'(1)) + IW'(sub_offs);
  assign vec_eff   = (st == ST_VEC) ? q_vec : '0;

  vis_regmap #(.REG_W(REG_W), .IW(IW), .NOPS(N_OPS)) u_map (
    .base (q_base),
    .vec  (vec_eff),
    .idx  (idx),
    .regs (regs)
  );

  assign iss_rd    = regs[0];
  assign iss_rs1   = regs[1];
  assign iss_rs2   = regs[2];
  assign vl_wr_val = EW'(elem_offs);

  vis_elem_ctl u_ctl (
    .run_vec   (st == ST_VEC),
    .run_scl   (st == ST_SCL),
    .pbit      (pbit),
    .zer       (q_zer),
    .ff        (q_ff),
    .iss_ready (iss_ready),
    .res_exc   (res_exc),
    .res_zero  (res_zero),
    .grp_end   (grp_end),
    .last_elem (last_elem),
    .iss_valid (iss_valid),
    .iss_zero  (iss_zero),
    .adv       (adv),
    .skip      (skip),
    .clr       (clr),
    .done      (done),
    .trap      (trap),
    .vl_wr_en  (vl_wr_en),
    .finish    (finish)
  );
endmodule

// File: rtl/vis_chk.sv
module vis_chk #(
  parameter int unsigned REG_W = 7,
  parameter int unsigned OW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_ready,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [REG_W-1:0] iss_rd,
  input logic [REG_W-1:0] iss_rs1,
  input logic [REG_W-1:0] iss_rs2,
  input logic             iss_zero,
  input logic             done,
  input logic             trap,
  input logic             vl_wr_en,
  input logic [OW-1:0]    elem_offs,
  input logic [1:0]       sub_offs
);
  AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |-> !iss_valid); // R1
  AST_DONE_TRAP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && trap)); // R8
  AST_TRAP_HOLDS_OFFS: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> ($stable(elem_offs) && $stable(sub_offs))); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_rd) && $stable(iss_rs1)
                                   && $stable(iss_rs2) && $stable(elem_offs) && $stable(sub_offs))); // R12
  AST_STALL_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |-> !(done || trap)); // R12
  AST_VLWR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    vl_wr_en |-> done); // R10
  AST_VLWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    vl_wr_en |=> (elem_offs == '0 && sub_offs == '0)); // R10
  AST_ZERO_IS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_zero |-> iss_valid); // R6
  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || trap) |=> ins_ready); // R1
endmodule

bind vec_issue_seq vis_chk #(.REG_W(REG_W), .OW(OW)) u_vis_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ins_ready (ins_ready),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .iss_rd    (iss_rd),
  .iss_rs1   (iss_rs1),
  .iss_rs2   (iss_rs2),
  .iss_zero  (iss_zero),
  .done      (done),
  .trap      (trap),
  .vl_wr_en  (vl_wr_en),
  .elem_offs (elem_offs),
  .sub_offs  (sub_offs)
);

// File: tb/tb_vec_issue_seq.sv
`timescale 1ns/1ps
module tb_vec_issue_seq;
  localparam int REG_W = 7;
  localparam int MAXVL = 8;
  localparam int EW = 4;
  localparam int OW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0, ins_ready;
  logic [REG_W-1:0] ins_rd = '0, ins_rs1 = '0, ins_rs2 = '0;
  logic ins_vd = 1'b0, ins_vs1 = 1'b0, ins_vs2 = 1'b0;
  logic [MAXVL-1:0] ins_pred = '0;
  logic ins_zeroing = 1'b0, ins_ffirst = 1'b0;
  logic [EW-1:0] vl_len = '0;
  logic [1:0] subvl = '0;
  logic iss_valid, iss_ready = 1'b0;
  logic [REG_W-1:0] iss_rd, iss_rs1, iss_rs2;
  logic iss_zero;
  logic res_exc = 1'b0, res_zero = 1'b0;
  logic [OW-1:0] elem_offs;
  logic [1:0] sub_offs;
  logic done, trap, vl_wr_en;
  logic [EW-1:0] vl_wr_val;

  int checks = 0;
  int errors = 0;
  int m_e = 0;
  int m_s = 0;

  always #2.5 clk = ~clk;

  vec_issue_seq #(.REG_W(REG_W), .MAXVL(MAXVL)) dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_rd(ins_rd), .ins_rs1(ins_rs1), .ins_rs2(ins_rs2),
    .ins_vd(ins_vd), .ins_vs1(ins_vs1), .ins_vs2(ins_vs2),
    .ins_pred(ins_pred), .ins_zeroing(ins_zeroing), .ins_ffirst(ins_ffirst),
    .vl_len(vl_len), .subvl(subvl),
    .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_rd(iss_rd), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2), .iss_zero(iss_zero),
    .res_exc(res_exc), .res_zero(res_zero),
    .elem_offs(elem_offs), .sub_offs(sub_offs),
    .done(done), .trap(trap), .vl_wr_en(vl_wr_en), .vl_wr_val(vl_wr_val)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // exc_e < 0: no fault; zero_e < 0: no zero result
  task automatic run_instr(input int vl, input int sv, input logic [MAXVL-1:0] mask,
                           input bit zer, input bit ff, input int zero_e,
                           input int exc_e, input int exc_s,
                           input bit vd, input bit vs1, input bit vs2,
                           input int rd, input int rs1, input int rs2, input int stall_mod);
    bit scalar, fin, rdy, pb, last, gend, ex, z;
    int cyc, idx;
    @(negedge clk);
    iss_ready = 1'b0; res_exc = 1'b0; res_zero = 1'b0;
    #1;
    chk(int'(elem_offs) == m_e, "R7 elem_offs", int'(elem_offs), m_e);
    chk(int'(sub_offs) == m_s, "R7 sub_offs", int'(sub_offs), m_s);
    chk(ins_ready == 1'b1, "R1 ready idle", int'(ins_ready), 1);
    ins_valid = 1'b1; ins_rd = REG_W'(rd); ins_rs1 = REG_W'(rs1); ins_rs2 = REG_W'(rs2);
    ins_vd = vd; ins_vs1 = vs1; ins_vs2 = vs2; ins_pred = mask;
    ins_zeroing = zer; ins_ffirst = ff; vl_len = EW'(vl); subvl = 2'(sv - 1);
    @(posedge clk); #1;
    ins_valid = 1'b0;
    scalar = !(vd || vs1 || vs2) || (vl == 0);
    fin = 1'b0; cyc = 0;
    while (!fin && cyc < 300) begin
      @(negedge clk);
      rdy = !(stall_mod != 0 && (cyc % stall_mod) == 1);
      chk(ins_ready == 1'b0, "R1 busy", int'(ins_ready), 0);
      if (scalar) begin
        iss_ready = rdy; res_exc = rdy && (exc_e >= 0); res_zero = 1'b0; #1;
        chk(iss_valid == 1'b1, "R13 valid", int'(iss_valid), 1);
        chk(int'(iss_rd) == rd, "R13 rd", int'(iss_rd), rd);
        chk(int'(iss_rs1) == rs1, "R13 rs1", int'(iss_rs1), rs1);
        chk(done == (rdy && exc_e < 0), "R13 done", int'(done), int'(rdy && exc_e < 0));
        chk(trap == (rdy && exc_e >= 0), "R8 scalar trap", int'(trap), int'(rdy && exc_e >= 0));
        if (rdy) fin = 1'b1;
      end else begin
        pb = mask[m_e]; last = (m_e == vl - 1); gend = (m_s == sv - 1);
        if (!pb && !zer) begin
          iss_ready = rdy; res_exc = 1'b0; res_zero = 1'b0; #1;
          chk(iss_valid == 1'b0, "R5 skip no issue", int'(iss_valid), 0);
          chk(done == last, "R9 done on skip", int'(done), int'(last));
          m_e++; m_s = 0;
          if (last) begin m_e = 0; fin = 1'b1; end
        end else if (!pb && ff) begin
          iss_ready = rdy; #1;
          chk(iss_valid == 1'b0, "R11 no issue", int'(iss_valid), 0);
          chk(done == 1'b1, "R11 done", int'(done), 1);
          chk(vl_wr_en == 1'b1, "R11 vl_wr_en", int'(vl_wr_en), 1);
          chk(int'(vl_wr_val) == m_e, "R11 vl_wr_val", int'(vl_wr_val), m_e);
          m_e = 0; m_s = 0; fin = 1'b1;
        end else begin
          idx = m_e * sv + m_s;
          ex = pb && m_e == exc_e && m_s == exc_s;
          z = pb && ff && m_e == zero_e;
          iss_ready = rdy; res_exc = rdy && (ex || (!pb && exc_e >= 0));
          res_zero = rdy && (z || !pb); #1;
          chk(iss_valid == 1'b1, "R3 issue", int'(iss_valid), 1);
          chk(int'(iss_rd) == (rd + (vd ? idx : 0)) % 128, "R2 rd", int'(iss_rd), (rd + (vd ? idx : 0)) % 128);
          chk(int'(iss_rs1) == (rs1 + (vs1 ? idx : 0)) % 128, "R2 rs1", int'(iss_rs1), (rs1 + (vs1 ? idx : 0)) % 128);
          chk(int'(iss_rs2) == (rs2 + (vs2 ? idx : 0)) % 128, "R2 rs2", int'(iss_rs2), (rs2 + (vs2 ? idx : 0)) % 128);
          if (pb) chk(iss_zero == 1'b0, "R4 active", int'(iss_zero), 0);
          else    chk(iss_zero == 1'b1, "R6 zero write", int'(iss_zero), 1);
          if (!rdy) begin
            chk(!done && !trap, "R12 stall", int'(done || trap), 0);
          end else if (ex) begin
            chk(trap == 1'b1 && done == 1'b0, "R8 trap", int'({trap, done}), 2);
            fin = 1'b1;
          end else if (z) begin
            chk(done == 1'b1 && vl_wr_en == 1'b1, "R10 end", int'({done, vl_wr_en}), 3);
            chk(int'(vl_wr_val) == m_e, "R10 vl_wr_val", int'(vl_wr_val), m_e);
            m_e = 0; m_s = 0; fin = 1'b1;
          end else begin
            chk(done == (gend && last), "R9 done", int'(done), int'(gend && last));
            chk(trap == 1'b0 && vl_wr_en == 1'b0, "R6 flags ignored", int'({trap, vl_wr_en}), 0);
            if (gend) begin m_s = 0; m_e++; end else m_s++;
            if (gend && last) begin m_e = 0; fin = 1'b1; end
          end
        end
      end
      cyc++;
      @(posedge clk); #1;
    end
    chk(fin, "R1 sequence ended", int'(fin), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(ins_ready == 1'b1, "R1 reset ready", int'(ins_ready), 1);
    chk(iss_valid == 1'b0, "R1 reset valid", int'(iss_valid), 0);
    chk(elem_offs == '0 && sub_offs == '0, "R9 reset offs", int'(elem_offs), 0);
    rst_n = 1'b1;
    // main sweep: lengths, sub-vector sizes, masks, zeroing
    for (int vl = 1; vl <= MAXVL; vl++)
      for (int sv = 1; sv <= 4; sv++)
        for (int mi = 0; mi < 2; mi++)
          for (int zz = 0; zz < 2; zz++)
            run_instr(vl, sv, (mi == 0) ? 8'hFF : 8'hA5, zz[0], 1'b0, -1, -1, 0,
                      1'b1, 1'b1, 1'b0, 120, 5, 64, 0);
    // fail-on-first zero result at each element
    for (int sv = 1; sv <= 4; sv++)
      for (int ze = 0; ze < 6; ze++)
        run_instr(6, sv, 8'hFF, 1'b0, 1'b1, ze, -1, 0, 1'b1, 1'b0, 1'b1, 10, 20, 30, 0);
    // fail-on-first: zeroing ends on masked element, non-zeroing skips it
    run_instr(8, 2, 8'b1111_0111, 1'b1, 1'b1, -1, -1, 0, 1'b1, 1'b1, 1'b1, 0, 40, 80, 0);
    run_instr(8, 2, 8'b1111_0111, 1'b0, 1'b1, -1, -1, 0, 1'b1, 1'b1, 1'b1, 0, 40, 80, 0);
    // fault mid-loop then resume from the faulting element
    run_instr(5, 3, 8'hFF, 1'b0, 1'b0, -1, 2, 1, 1'b1, 1'b0, 1'b0, 8, 9, 10, 0);
    run_instr(5, 3, 8'hFF, 1'b0, 1'b0, -1, -1, 0, 1'b1, 1'b0, 1'b0, 8, 9, 10, 0);
    // stalls
    for (int sv = 1; sv <= 4; sv++)
      run_instr(7, sv, 8'h6D, 1'b1, 1'b0, -1, -1, 0, 1'b1, 1'b1, 1'b1, 3, 50, 100, 3);
    // scalar paths
    run_instr(4, 2, 8'h00, 1'b0, 1'b0, -1, -1, 0, 1'b0, 1'b0, 1'b0, 17, 18, 19, 0);
    run_instr(0, 1, 8'hFF, 1'b0, 1'b0, -1, -1, 0, 1'b1, 1'b1, 1'b0, 33, 34, 35, 2);
    run_instr(4, 1, 8'hFF, 1'b0, 1'b0, -1, 0, 0, 1'b0, 1'b0, 1'b0, 1, 2, 3, 0);
    @(negedge clk); #1;
    chk(int'(elem_offs) == m_e && int'(sub_offs) == m_s, "R7 final offs", int'(elem_offs), m_e);
    summary();
  end
endmodule